// File: doc/BRIEF.md
# Two-Register Byte Shuffle Unit

This unit is a SIMD permute datapath. It takes two 128-bit source operands and one 128-bit control operand, and it produces one registered 128-bit result. The two sources are joined into a 32-byte lookup table. Each of the 16 control bytes sets the result byte at its own position. A control byte either reads any table byte or forces one of three fixed constants, so one operation performs 16 independent lookups.

A one-bit opcode selects a second operation, a bitwise select. In that mode the control operand acts as a mask, and each result bit comes from the second source where the mask bit is 1 and from the first source where it is 0. A valid strobe goes in with the operands and comes out with the result. The latency is always one clock cycle, whatever the data values are.

Top module: `byte_permute_unit`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `out_data` is all zeros on the following clock edge.
- R2: `out_valid` is high exactly one cycle after an accepted `in_valid`, with no dependence on operand values or opcode.
- R3: Table bytes 0..15 are `src_a` bytes from bits 127:120 downward, and table bytes 16..31 are `src_b` bytes in the same order. A control byte with bit 7 = 0 returns table byte `ctrl[4:0]`, and bits 6:5 are ignored.
- R4: A control byte whose top two bits are `10` yields 0x00.
- R5: A control byte whose top three bits are `110` yields 0xFF.
- R6: A control byte whose top three bits are `111` yields 0x80.
- R7: Control byte i (byte 0 = bits 127:120) sets only result byte i, and all 16 bytes are resolved independently in one operation.
- R8: With `in_op` = 1 each result bit equals the `src_b` bit where the `ctrl` bit is 1 and the `src_a` bit where it is 0. With `in_op` = 0 the shuffle of R3–R7 applies.
- R9: When `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| in_op | input | 1 | 0 = byte shuffle, 1 = bitwise select |
| src_a | input | 128 | First source (table bytes 0..15) |
| src_b | input | 128 | Second source (table bytes 16..31) |
| ctrl | input | 128 | Shuffle controls or select mask |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Registered result |

## Verification
The assertions assume that `in_op`, `ctrl` and both sources are known (not X) whenever `in_valid` is high, and that the operands are launched only as one-cycle presentations sampled at the rising edge. The stimulus drives every input away from the clock edge, holds `in_valid` low in idle gaps while it changes the operands freely, and mixes directed control bytes from every encoding class with random words. That mix covers the constant encodings and the table boundaries at indices 15 and 16.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
    parameter int NBYTES   = 16;
    parameter int BYTE_W   = 8;
    localparam int WORD_W  = NBYTES * BYTE_W;
    localparam int TBL_N   = 2 * NBYTES;
    localparam int TBL_W   = TBL_N * BYTE_W;
    localparam int IDX_W   = $clog2(TBL_N);

    typedef enum logic { OP_SHUFFLE = 1'b0, OP_BITSEL = 1'b1 } op_e;

    typedef enum logic [1:0] {
        K_TABLE = 2'd0,
        K_ZERO  = 2'd1,
        K_ONES  = 2'd2,
        K_MSB   = 2'd3
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } ctl_dec_t;

    function automatic ctl_dec_t decode_ctl(input logic [BYTE_W-1:0] c);
        ctl_dec_t d;
        d.idx = c[IDX_W-1:0];
        if (!c[7])       d.kind = K_TABLE;
        else if (!c[6])  d.kind = K_ZERO;
        else if (!c[5])  d.kind = K_ONES;
        else             d.kind = K_MSB;
        return d;
    endfunction
endpackage

// File: rtl/perm_lane.sv
module perm_lane
    import shuf_pkg::*;
(
    input  logic [TBL_W-1:0]  tbl,
    input  logic [BYTE_W-1:0] ctl,
    output logic [BYTE_W-1:0] res
);
    ctl_dec_t dec;
    logic [BYTE_W-1:0] picked;

    always_comb begin
        dec    = decode_ctl(ctl);
        picked = tbl[TBL_W-1-BYTE_W*int'(dec.idx) -: BYTE_W];
        case (dec.kind)
            K_ZERO:  res = 8'h00;
            K_ONES:  res = 8'hFF;
            K_MSB:   res = 8'h80;
            default: res = picked;
        endcase
    end
endmodule

// File: rtl/bit_select.sv
module bit_select
    import shuf_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] res
);
    always_comb res = (b & mask) | (a & ~mask);
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import shuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_op,
    input  logic [WORD_W-1:0]  src_a,
    input  logic [WORD_W-1:0]  src_b,
    input  logic [WORD_W-1:0]  ctrl,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data
);
    logic [TBL_W-1:0]  table_w;
    logic [WORD_W-1:0] shuf_res;
    logic [WORD_W-1:0] sel_res;
    logic [WORD_W-1:0] next_res;
    op_e               op;

    assign table_w = {src_a, src_b};
    assign op      = op_e'(in_op);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int HI = WORD_W - 1 - BYTE_W * i;
        perm_lane u_lane (
            .tbl (table_w),
            .ctl (ctrl[HI -: BYTE_W]),
            .res (shuf_res[HI -: BYTE_W])
        );
    end

    bit_select u_sel (
        .a    (src_a),
        .b    (src_b),
        .mask (ctrl),
        .res  (sel_res)
    );

    always_comb next_res = (op == OP_BITSEL) ? sel_res : shuf_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_res;
        end
    end
endmodule

// File: rtl/byte_permute_unit_chk.sv
module byte_permute_unit_chk
    import shuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_op,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic [WORD_W-1:0] ctrl,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

    // R9
    hold_data_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data));

    // R8
    bitsel_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=>
        out_data == (($past(src_b) & $past(ctrl)) | ($past(src_a) & ~$past(ctrl))));

    // R4
    zero_const_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && ctrl[127:126] == 2'b10) |=> out_data[127:120] == 8'h00);

    // R5
    ones_const_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && ctrl[127:125] == 3'b110) |=> out_data[127:120] == 8'hFF);

    // R6
    msb_const_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && ctrl[127:125] == 3'b111) |=> out_data[127:120] == 8'h80);

    // R3
    first_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && ctrl[127:120] == 8'h00) |=> out_data[127:120] == $past(src_a[127:120]));
endmodule

bind byte_permute_unit byte_permute_unit_chk u_chk (.*);

// File: tb/byte_permute_unit_tb.sv
module byte_permute_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_op;
    logic [127:0] src_a, src_b, ctrl;
    logic         out_valid;
    logic [127:0] out_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    bit           exp_valid;
    logic [127:0] exp_data;

    always #4 clk = ~clk;

    byte_permute_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] ref_byte(input logic [127:0] a, input logic [127:0] b,
                                            input logic [7:0] c);
        int k;
        if (c[7:6] == 2'b10) return 8'h00;
        if (c[7:5] == 3'b110) return 8'hFF;
        if (c[7:5] == 3'b111) return 8'h80;
        k = c % 32;
        if (k < 16) return a[127 - 8*k -: 8];
        return b[127 - 8*(k-16) -: 8];
    endfunction

    function automatic string tag_for(input bit op, input logic [7:0] c);
        if (op) return "R8";
        if (c[7:6] == 2'b10) return "R4";
        if (c[7:5] == 3'b110) return "R5";
        if (c[7:5] == 3'b111) return "R6";
        return "R3/R7";
    endfunction

    task automatic compare();
        total++;
        if (out_valid !== exp_valid) begin
            bad++;
            $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, exp_valid);
        end
        for (int i = 0; i < 16; i++) begin
            total++;
            if (out_data[127-8*i -: 8] !== exp_data[127-8*i -: 8]) begin
                bad++;
                $display("FAIL %s byte %0d act=%h exp=%h", tag_for(last_op, last_ctrl[127-8*i -: 8]),
                         i, out_data[127-8*i -: 8], exp_data[127-8*i -: 8]);
            end
        end
    endtask

    bit           last_op;
    logic [127:0] last_ctrl;

    // One step: drive at negedge, expectation updated per requirement, check next negedge
    task automatic step(input bit v, input bit op, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] c);
        in_valid = v; in_op = op; src_a = a; src_b = b; ctrl = c;
        @(negedge clk);
        exp_valid = v;
        if (v) begin
            last_op = op; last_ctrl = c;
            if (op) exp_data = (b & c) | (a & ~c);           // R8
            else for (int i = 0; i < 16; i++)                 // R7
                exp_data[127-8*i -: 8] = ref_byte(a, b, c[127-8*i -: 8]);
        end                                                   // else R9: hold
        compare();
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    logic [127:0] A_PAT = 128'h000102030405060708090A0B0C0D0E0F;
    logic [127:0] B_PAT = 128'h101112131415161718191A1B1C1D1E1F;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_op = 1'b0;
        src_a = '1; src_b = '1; ctrl = '0;
        last_op = 0; last_ctrl = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            bad++;
            $display("FAIL R1 reset act=%0b/%h exp=0/0", out_valid, out_data);
        end
        rst = 1'b0; in_valid = 1'b0;
        exp_valid = 0; exp_data = '0;

        // R3 identity over first source and second source, R7 reversal
        step(1, 0, A_PAT, B_PAT, 128'h000102030405060708090A0B0C0D0E0F);
        step(1, 0, A_PAT, B_PAT, 128'h101112131415161718191A1B1C1D1E1F);
        step(1, 0, A_PAT, B_PAT, 128'h1F1E1D1C1B1A19180F0E0D0C0B0A0900);
        // R3 boundary 15/16 and ignored bits 6:5
        step(1, 0, A_PAT, B_PAT, 128'h0F106F707F202F3F4F5F604050301F0E);
        // R4 R5 R6 constants mixed with lookups
        step(1, 0, A_PAT, B_PAT, 128'h80BFC0DFE0FF00A0C5E7101F9ADE0F31);
        // R9 idle with changing inputs
        step(0, 1, rnd128(), rnd128(), rnd128());
        step(0, 0, rnd128(), rnd128(), rnd128());
        // R8 select
        step(1, 1, '0, '1, 128'hF0F0_0000_FFFF_1234_5678_9ABC_DEF0_0F0F);
        step(1, 1, A_PAT, B_PAT, '0);
        step(1, 1, A_PAT, B_PAT, '1);
        // R2 back-to-back and mixed random
        for (int n = 0; n < 300; n++)
            step(($urandom % 4) != 0, $urandom % 2, rnd128(), rnd128(), rnd128());
        // mid-run reset R1
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            bad++;
            $display("FAIL R1 reset act=%0b/%h exp=0/0", out_valid, out_data);
        end
        rst = 1'b0;
        exp_valid = 0; exp_data = '0;
        step(0, 0, '0, '0, '0);
        step(1, 0, rnd128(), rnd128(), rnd128());
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule